// File: doc/BRIEF.md
# Receive FIFO Packet Framer

This block sits behind a receive MAC. It takes the finished frame as a byte stream, one byte per cycle with a last-byte marker and three error flags, and writes it into a word-wide FIFO. Each stored frame is laid out as a fixed marker word, then a descriptor word that carries the status and the byte length, then the payload packed into 32-bit words.

Software drains the FIFO through a single read port. It watches a pending-frame counter, pops the marker, takes the length from the descriptor, and pops the payload words. A frame becomes visible only once its last byte has been stored. A frame that cannot fit is discarded whole and counted. A flush request empties the store. A sticky interrupt flag reports each stored frame.

Top module: `rxf_framer`

## Requirements
- R1: The first word of every stored frame is the marker 0x0143414D.
- R2: The second word holds the status in bits [31:16] and the byte length in bits [15:0]. Status bit 7 (header bit 23) is set when no error flag was raised. Status bit 6 (header bit 22) is the alignment error. Status bit 5 (header bit 21) is the length error. Status bit 4 (header bit 20) is the CRC error. All other status bits are zero. Frames with errors are stored like any other frame.
- R3: The payload follows as ceil(length/4) words. Byte i of the frame sits in word i/4 at bits [8*(i%4)+7 : 8*(i%4)], and unused bytes of the last word are zero.
- R4: `frame_count` increments in the same cycle that the last byte of a stored frame is accepted, and never earlier.
- R5: `frame_count` decrements on the pop of the final payload word of the oldest frame. It does not change on any other pop.
- R6: A `count_clr` pulse sets `frame_count` to 0. Later final-word pops do not take it below 0, and the stored data stays readable.
- R7: A frame that does not fit in the free FIFO space is discarded completely. `drop_count` increments by one, `frame_count` is unchanged, and no word of the frame becomes readable.
- R8: A `fifo_flush` pulse empties the FIFO and clears `frame_count` at the next edge. `flush_busy` then reads 1 for FLUSH_CYCLES cycles and returns to 0 by itself. A frame that is in reception when the flush is applied, or that starts while `flush_busy` is 1, is discarded without counting as a drop.
- R9: `rx_irq` is set by every stored frame and stays set until an `irq_clr` pulse.
- R10: While no committed word is waiting, `rd_data` reads 0 and `rd_pop` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive byte valid |
| in_byte | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_crc_err | input | 1 | CRC error flag, sampled with the last byte |
| in_len_err | input | 1 | Length error flag, sampled with the last byte |
| in_align_err | input | 1 | Alignment error flag, sampled with the last byte |
| rd_pop | input | 1 | Pops the word shown on rd_data |
| rd_data | output | 32 | Head word of the FIFO |
| frame_count | output | $clog2(DEPTH) | Complete frames pending |
| count_clr | input | 1 | Clears frame_count |
| fifo_flush | input | 1 | Requests a FIFO flush |
| flush_busy | output | 1 | High while a flush is in progress |
| drop_count | output | 16 | Frames discarded for lack of room (saturating) |
| rx_irq | output | 1 | Sticky frame-received interrupt flag |
| irq_clr | input | 1 | Clears rx_irq |

## Verification
The hardest case is a frame that starts with enough room for its marker and descriptor but runs out of space part-way through its payload. In that case words have already been written past the committed point and must be abandoned. The bench first parks a 200-byte frame in the 64-word store without reading it, then sends a 60-byte frame. That frame overflows after ten payload words. The bench checks that only the parked frame is readable and that the next frame lands intact after the pointers have wrapped. A flush that lands in the middle of a frame is forced by stopping the byte stream part-way, pulsing the flush, and then finishing the frame during and after the busy window.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [31:0] RXF_MARKER = 32'h0143_414D;

    typedef enum logic [1:0] {
        PK_IDLE,
        PK_RECV,
        PK_SKIP
    } pk_state_e;

    typedef enum logic [1:0] {
        RD_MARK,
        RD_DESC,
        RD_BODY
    } rd_state_e;

    // Write requests from the byte packer to the word store
    typedef struct packed {
        logic        start;
        logic        word_wr;
        logic [31:0] word;
        logic        frame_end;
        logic [31:0] desc;
    } pk_wr_t;

    function automatic logic [31:0] rxf_desc(
        input logic        crc_e,
        input logic        len_e,
        input logic        aln_e,
        input logic [15:0] nbytes
    );
        logic good;
        good = !(crc_e || len_e || aln_e);
        return {8'h00, good, aln_e, len_e, crc_e, 4'h0, nbytes};
    endfunction

    function automatic logic [14:0] rxf_words(input logic [15:0] nbytes);
        logic [16:0] sum;
        sum = {1'b0, nbytes} + 17'd3;
        return sum[16:2];
    endfunction

endpackage

// File: rtl/rxf_packer.sv
module rxf_packer
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    input  logic       in_crc_err,
    input  logic       in_len_err,
    input  logic       in_align_err,
    output pk_wr_t     wr
);

    pk_state_e   state;
    logic [31:0] acc;
    logic [1:0]  lane;
    logic [15:0] nbytes;

    logic        accept;
    logic        first;
    logic [1:0]  cur_lane;
    logic [31:0] cur_acc;
    logic [31:0] merged;
    logic [15:0] cur_len;

    always_comb begin
        accept   = in_valid && !hold && (state != PK_SKIP);
        first    = (state == PK_IDLE);
        cur_lane = first ? 2'd0 : lane;
        cur_acc  = first ? 32'h0 : acc;
        merged   = cur_acc | ({24'h0, in_byte} << {cur_lane, 3'b000});
        cur_len  = first ? 16'd1 : ((nbytes == 16'hFFFF) ? nbytes : nbytes + 16'd1);

        wr = '0;
        if (accept) begin
            wr.start = first;
            if (cur_lane == 2'd3 || in_last) begin
                wr.word_wr = 1'b1;
                wr.word    = merged;
            end
            if (in_last) begin
                wr.frame_end = 1'b1;
                wr.desc      = rxf_desc(in_crc_err, in_len_err, in_align_err, cur_len);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PK_IDLE;
            acc    <= '0;
            lane   <= '0;
            nbytes <= '0;
        end else if (hold) begin
            acc  <= '0;
            lane <= '0;
            if (in_valid && in_last)
                state <= PK_IDLE;
            else if (state == PK_RECV || in_valid)
                state <= PK_SKIP;
        end else if (state == PK_SKIP) begin
            if (in_valid && in_last)
                state <= PK_IDLE;
        end else if (accept) begin
            if (in_last) begin
                state <= PK_IDLE;
                acc   <= '0;
                lane  <= '0;
            end else begin
                state  <= PK_RECV;
                nbytes <= cur_len;
                lane   <= cur_lane + 2'd1;
                acc    <= (cur_lane == 2'd3) ? 32'h0 : merged;
            end
        end
    end

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == PK_SKIP) |-> !(wr.start || wr.word_wr || wr.frame_end)) else $error("skip"); // R8

endmodule

// File: rtl/rxf_buffer.sv
module rxf_buffer
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  pk_wr_t      wr,
    input  logic        pop,
    output logic [31:0] rd_data,
    output logic        pop_ok,
    output logic        commit,
    output logic [15:0] drop_count
);

    logic [31:0]   mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] commit_ptr;
    logic [PW-1:0] tent_ptr;
    logic          dropping;

    logic [PW-1:0] used_c;
    logic          start_room;
    logic [PW-1:0] tent_eff;
    logic          drop_pre;
    logic          word_room;
    logic          word_go;
    logic          drop_eff;
    logic [PW-1:0] tent_next;
    logic          drop_go;
    logic          avail;

    always_comb begin
        used_c     = commit_ptr - rd_ptr;
        start_room = (used_c <= PW'(DEPTH - 2));
        tent_eff   = wr.start ? (commit_ptr + PW'(2)) : tent_ptr;
        drop_pre   = wr.start ? !start_room : dropping;
        word_room  = ((tent_eff - rd_ptr) < PW'(DEPTH));
        word_go    = wr.word_wr && !drop_pre && word_room;
        drop_eff   = drop_pre || (wr.word_wr && !word_room);
        tent_next  = word_go ? (tent_eff + PW'(1)) : tent_eff;
        commit     = wr.frame_end && !drop_eff;
        drop_go    = wr.frame_end && drop_eff;
        avail      = (rd_ptr != commit_ptr);
        pop_ok     = pop && avail && !flush;
        rd_data    = avail ? mem[rd_ptr[AW-1:0]] : 32'h0;
    end

    always_ff @(posedge clk) begin
        if (wr.start && start_room)
            mem[commit_ptr[AW-1:0]] <= RXF_MARKER;
        if (word_go)
            mem[tent_eff[AW-1:0]] <= wr.word;
        if (commit)
            mem[commit_ptr[AW-1:0] + AW'(1)] <= wr.desc;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr     <= '0;
            commit_ptr <= '0;
            tent_ptr   <= '0;
            dropping   <= 1'b0;
        end else begin
            if (pop_ok)
                rd_ptr <= rd_ptr + PW'(1);
            tent_ptr <= tent_next;
            dropping <= wr.frame_end ? 1'b0 : drop_eff;
            if (commit)
                commit_ptr <= tent_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            drop_count <= '0;
        else if (drop_go && drop_count != 16'hFFFF)
            drop_count <= drop_count + 16'd1;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (rd_ptr == commit_ptr)) else $error("flush"); // R8
    AST_DROP_HOLDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (drop_go && !flush) |=> $stable(commit_ptr)) else $error("drop"); // R7
    AST_READ_BEHIND_COMMIT: assert property (@(posedge clk) disable iff (rst)
        ((commit_ptr - rd_ptr) <= PW'(DEPTH))) else $error("order"); // R10

endmodule

// File: rtl/rxf_tally.sv
module rxf_tally
    import rxf_pkg::*;
#(
    parameter int CNT_W = 6
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             commit,
    input  logic             pop_ok,
    input  logic [31:0]      head_word,
    input  logic             count_clr,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] frame_count,
    output logic             rx_irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    rd_state_e   state;
    logic [14:0] left;
    logic        frame_done;

    assign frame_done = pop_ok && (state == RD_BODY) && (left == 15'd1);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state <= RD_MARK;
            left  <= '0;
        end else if (pop_ok) begin
            unique case (state)
                RD_MARK: state <= RD_DESC;
                RD_DESC: begin
                    left  <= rxf_words(head_word[15:0]);
                    state <= (rxf_words(head_word[15:0]) == 15'd0) ? RD_MARK : RD_BODY;
                end
                RD_BODY: begin
                    left <= left - 15'd1;
                    if (left == 15'd1)
                        state <= RD_MARK;
                end
                default: state <= RD_MARK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            frame_count <= '0;
        end else if (count_clr) begin
            frame_count <= commit ? CNT_W'(1) : '0;
        end else if (commit && !frame_done) begin
            if (frame_count != CNT_MAX)
                frame_count <= frame_count + CNT_W'(1);
        end else if (frame_done && !commit) begin
            if (frame_count != '0)
                frame_count <= frame_count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_irq <= 1'b0;
        else if (commit)
            rx_irq <= 1'b1;
        else if (irq_clr)
            rx_irq <= 1'b0;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!count_clr && !flush) |=> ((frame_count == $past(frame_count)) ||
                                    (frame_count == $past(frame_count) + CNT_W'(1)) ||
                                    (frame_count == $past(frame_count) - CNT_W'(1)))) else $error("step"); // R4
    AST_IRQ_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit |=> rx_irq) else $error("irq"); // R9

endmodule

// File: rtl/rxf_framer.sv
module rxf_framer
    import rxf_pkg::*;
#(
    parameter int DEPTH        = 64,
    parameter int FLUSH_CYCLES = 4,
    localparam int CNT_W = $clog2(DEPTH),
    localparam int FW    = $clog2(FLUSH_CYCLES + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    input  logic             in_crc_err,
    input  logic             in_len_err,
    input  logic             in_align_err,
    input  logic             rd_pop,
    output logic [31:0]      rd_data,
    output logic [CNT_W-1:0] frame_count,
    input  logic             count_clr,
    input  logic             fifo_flush,
    output logic             flush_busy,
    output logic [15:0]      drop_count,
    output logic             rx_irq,
    input  logic             irq_clr
);

    logic          flush_do;
    logic [FW-1:0] flush_left;
    pk_wr_t        wr;
    logic          pop_ok;
    logic          commit;

    assign flush_do = fifo_flush && !flush_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_busy <= 1'b0;
            flush_left <= '0;
        end else if (flush_do) begin
            flush_busy <= 1'b1;
            flush_left <= FW'(FLUSH_CYCLES - 1);
        end else if (flush_busy) begin
            if (flush_left == '0)
                flush_busy <= 1'b0;
            else
                flush_left <= flush_left - FW'(1);
        end
    end

    rxf_packer i_packer (
        .clk          (clk),
        .rst          (rst),
        .hold         (flush_do || flush_busy),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_last      (in_last),
        .in_crc_err   (in_crc_err),
        .in_len_err   (in_len_err),
        .in_align_err (in_align_err),
        .wr           (wr)
    );

    rxf_buffer #(.DEPTH(DEPTH)) i_buffer (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_do),
        .wr         (wr),
        .pop        (rd_pop),
        .rd_data    (rd_data),
        .pop_ok     (pop_ok),
        .commit     (commit),
        .drop_count (drop_count)
    );

    rxf_tally #(.CNT_W(CNT_W)) i_tally (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush_do),
        .commit      (commit),
        .pop_ok      (pop_ok),
        .head_word   (rd_data),
        .count_clr   (count_clr),
        .irq_clr     (irq_clr),
        .frame_count (frame_count),
        .rx_irq      (rx_irq)
    );

    AST_FLUSH_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
        flush_do |=> flush_busy) else $error("busy"); // R8
    AST_FLUSH_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        flush_do |=> (frame_count == '0)) else $error("fcount"); // R8

endmodule

// File: tb/test_rxf_framer.sv
module test_rxf_framer;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_last, in_crc_err, in_len_err, in_align_err;
    logic [7:0]  in_byte;
    logic        rd_pop, count_clr, fifo_flush, irq_clr;
    logic [31:0] rd_data;
    logic [5:0]  frame_count;
    logic        flush_busy;
    logic [15:0] drop_count;
    logic        rx_irq;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    rxf_framer i_rxf_framer (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
        .in_crc_err(in_crc_err), .in_len_err(in_len_err), .in_align_err(in_align_err),
        .rd_pop(rd_pop), .rd_data(rd_data), .frame_count(frame_count),
        .count_clr(count_clr), .fifo_flush(fifo_flush), .flush_busy(flush_busy),
        .drop_count(drop_count), .rx_irq(rx_irq), .irq_clr(irq_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Driver: sends a frame and, when it should be stored, pushes its words to the scoreboard
    task automatic send_frame(input int n, input int seed, input bit crc, input bit lenb,
                              input bit aln, input bit keep);
        logic [31:0] w;
        if (keep) begin
            exp_q.push_back(32'h0143_414D);
            exp_q.push_back({8'h00, !(crc || lenb || aln), aln, lenb, crc, 4'h0, 16'(n)});
            for (int wi = 0; wi < (n + 3) / 4; wi++) begin
                w = 32'h0;
                for (int b = 0; b < 4; b++)
                    if (wi * 4 + b < n)
                        w = w | (32'((seed + (wi * 4 + b) * 7) & 8'hFF) << (8 * b));
                exp_q.push_back(w);
            end
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid     = 1'b1;
            in_byte      = 8'((seed + i * 7) & 8'hFF);
            in_last      = (i == n - 1);
            in_crc_err   = (i == n - 1) && crc;
            in_len_err   = (i == n - 1) && lenb;
            in_align_err = (i == n - 1) && aln;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        in_crc_err = 1'b0; in_len_err = 1'b0; in_align_err = 1'b0;
    endtask

    // Monitor: pops one frame and compares each word against the scoreboard
    task automatic drain_frame();
        int nw;
        logic [31:0] e;
        nw = 2 + ((int'(exp_q[1][15:0]) + 3) / 4);
        for (int k = 0; k < nw; k++) begin
            e = exp_q.pop_front();
            if (k == 0)      chk("R1 marker word", rd_data, e);
            else if (k == 1) chk("R2 descriptor word", rd_data, e);
            else             chk("R3 payload word", rd_data, e);
            if (k == nw - 1) chk("R5 count held before final pop", 32'(frame_count), 32'(exp_cnt));
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
        if (exp_cnt > 0) exp_cnt--;
        chk("R5 count after final pop", 32'(frame_count), 32'(exp_cnt));
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_byte = 8'h0; in_last = 1'b0;
        in_crc_err = 1'b0; in_len_err = 1'b0; in_align_err = 1'b0;
        rd_pop = 1'b0; count_clr = 1'b0; fifo_flush = 1'b0; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk("R4 reset count", 32'(frame_count), 32'd0);
        chk("R10 reset rd_data", rd_data, 32'h0);
        chk("R8 reset busy", 32'(flush_busy), 32'd0);
        chk("R7 reset drops", 32'(drop_count), 32'd0);
        chk("R9 reset irq", 32'(rx_irq), 32'd0);

        // Pop while empty is ignored
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
        chk("R10 empty pop data", rd_data, 32'h0);
        chk("R10 empty pop count", 32'(frame_count), 32'd0);

        // Basic 64-byte good frame
        send_frame(64, 3, 0, 0, 0, 1); exp_cnt++;
        chk("R4 count after frame", 32'(frame_count), 32'(exp_cnt));
        chk("R9 irq after frame", 32'(rx_irq), 32'd1);
        drain_frame();

        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk("R9 irq cleared", 32'(rx_irq), 32'd0);

        // Errored and odd-length frames, queued together
        send_frame(61, 17, 1, 0, 0, 1); exp_cnt++;
        send_frame(5, 200, 0, 1, 1, 1); exp_cnt++;
        send_frame(1, 90, 0, 0, 0, 1); exp_cnt++;
        chk("R4 three pending", 32'(frame_count), 32'd3);
        drain_frame(); drain_frame(); drain_frame();

        // Count clear with frames pending
        send_frame(12, 5, 0, 0, 0, 1); exp_cnt++;
        send_frame(9, 44, 0, 0, 0, 1); exp_cnt++;
        count_clr = 1'b1; @(negedge clk); count_clr = 1'b0; exp_cnt = 0;
        chk("R6 count cleared", 32'(frame_count), 32'd0);
        drain_frame(); drain_frame();
        chk("R6 count stays zero", 32'(frame_count), 32'd0);

        // Overflow: frame larger than the store
        send_frame(300, 8, 0, 0, 0, 0);
        chk("R7 oversize dropped", 32'(drop_count), 32'd1);
        chk("R7 oversize not counted", 32'(frame_count), 32'd0);
        chk("R7 oversize not readable", rd_data, 32'h0);
        // Overflow part-way through payload
        send_frame(200, 11, 0, 0, 0, 1); exp_cnt++;
        send_frame(60, 77, 0, 0, 0, 0);
        chk("R7 partial overflow dropped", 32'(drop_count), 32'd2);
        chk("R7 partial overflow count", 32'(frame_count), 32'd1);
        drain_frame();
        send_frame(60, 77, 0, 0, 0, 1); exp_cnt++;
        drain_frame();

        // Flush with a frame waiting
        send_frame(20, 1, 0, 0, 0, 0);
        chk("R4 frame before flush", 32'(frame_count), 32'd1);
        fifo_flush = 1'b1; @(negedge clk); fifo_flush = 1'b0;
        chk("R8 busy after request", 32'(flush_busy), 32'd1);
        chk("R8 count flushed", 32'(frame_count), 32'd0);
        chk("R8 data flushed", rd_data, 32'h0);
        repeat (3) @(negedge clk);
        chk("R8 busy last cycle", 32'(flush_busy), 32'd1);
        @(negedge clk);
        chk("R8 busy self-clears", 32'(flush_busy), 32'd0);

        // Flush arriving in the middle of a frame
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); in_valid = 1'b1; in_byte = 8'(i); in_last = 1'b0;
        end
        @(negedge clk); in_valid = 1'b0; fifo_flush = 1'b1;
        @(negedge clk); fifo_flush = 1'b0;
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1; in_byte = 8'(i); in_last = (i == 7);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        chk("R8 mid-frame discarded", 32'(frame_count), 32'd0);
        chk("R8 mid-frame not a drop", 32'(drop_count), 32'd2);
        chk("R8 mid-frame no data", rd_data, 32'h0);
        send_frame(33, 66, 0, 0, 0, 1); exp_cnt = 1;
        drain_frame();

        report();
    end

endmodule